// File: doc/BRIEF.md
# Receive Monitor Descriptor Builder

The block turns receive-side events into fixed-size monitor descriptors of eight 32-bit words and hands them to a ring writer over a valid/ready stream. Each completed MPDU yields one descriptor. It carries the link-descriptor address, the MSDU count, the fragment and TID information and the error status of that MPDU. It also carries the number of status buffers the current PPDU has used so far and the identifier latched at the start of that PPDU.

When marker generation is switched on, the end of a PPDU or a flush produces a separate descriptor that marks the boundary. In that descriptor the end-of-PPDU bit is set and all per-frame content is cleared. A marker always follows every MPDU descriptor accepted before it. The block holds a single output descriptor. An MPDU event that cannot be accepted is dropped and recorded in a sticky overflow flag.

Top module: `mon_desc_builder`

## Requirements
- R1: Word 0 holds link address bits [31:0]. Word 1 holds address bits [39:32] in [7:0] and zero above. Word 2 holds the MSDU count in [7:0], the fragment flag in [8] and the TID in [31:28], with zero elsewhere. Words 3 to 5 are zero. An accepted event shows on the output after one clock edge.
- R2: The reason code is word 6 bits [1:0]. It is 0 for an MPDU flagged with an error, 1 for a normal MPDU or a PPDU-end marker, and 2 for a flush marker. The value 3 never appears.
- R3: Word 6 bits [6:2] carry the error code only when the reason is 0. Otherwise they are zero.
- R4: Word 6 bits [10:7] carry the fragment number only for an MPDU whose fragment flag is set. Otherwise they are zero.
- R5: Word 6 bit [11] copies the frameless-BAR flag of an MPDU.
- R6: With markers enabled, a PPDU end or a flush produces a descriptor with word 6 bit [16] set, in the cycle after the event once the output slot is free. In that descriptor words 0 to 3 and word 6 bits [11:7] are zero. With markers disabled, neither event produces any descriptor. MPDU descriptors have bit [16] clear.
- R7: Word 6 bits [15:12] hold the status-buffer strobes counted since the PPDU began, and the count saturates at 15. The count clears after a marker is loaded, or at PPDU start when markers are disabled.
- R8: The PPDU identifier latched at PPDU start (0 after reset) appears in word 7 bits [15:0]. Word 7 bits [31:16] and word 6 bits [31:17] are zero.
- R9: While valid is high and ready is low, valid and the descriptor stay unchanged.
- R10: An MPDU event that arrives while the slot is held, or while a marker is queued, is dropped, and the overflow flag sets and stays set until reset.
- R11: A PPDU end that arrives together with an MPDU event, or while an MPDU descriptor is stalled, yields its marker only after that MPDU descriptor.
- R12: After reset, valid and the overflow flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mark_en | input | 1 | Enables boundary marker descriptors |
| mpdu_vld | input | 1 | MPDU-complete event |
| mpdu_link_addr | input | 40 | Link-descriptor address |
| mpdu_msdu_cnt | input | 8 | MSDUs in the MPDU |
| mpdu_frag_flag | input | 1 | MPDU is a fragment |
| mpdu_frag_num | input | 4 | Fragment number |
| mpdu_tid | input | 4 | Traffic identifier |
| mpdu_fbar | input | 1 | Frameless-BAR flag |
| mpdu_err | input | 1 | MPDU carries an error |
| mpdu_err_code | input | 5 | Error code |
| stat_buf_used | input | 1 | One status buffer consumed |
| ppdu_start | input | 1 | PPDU start event |
| ppdu_id_in | input | 16 | Identifier of the starting PPDU |
| ppdu_end | input | 1 | PPDU end event |
| ppdu_flush | input | 1 | Flush event |
| desc_vld | output | 1 | Descriptor valid |
| desc_rdy | input | 1 | Ring writer ready |
| desc_data | output | 256 | Descriptor, word n at bits [32n+31:32n] |
| ovf_sticky | output | 1 | Sticky overflow flag |

## Verification
The checks on the output assume that the ring writer samples a descriptor only while valid is high. They also assume that every field rule holds in any cycle where valid is high, whatever the input pattern. The assertions further assume that event pulses are single-cycle and that the error code input is within 5 bits. The stimulus never drives a status strobe in the same cycle as a clearing event, and never starts a PPDU while a marker is queued, so the expected counts stay unambiguous. Overflow is provoked only on purpose, in the stall scenario.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int DESC_W    = WORD_W * NUM_WORDS;
  localparam int ADDR_W    = 40;
  localparam int ADDR_LO_W = 32;
  localparam int ADDR_HI_W = ADDR_W - ADDR_LO_W;
  localparam int MSDU_W    = 8;
  localparam int TID_W     = 4;
  localparam int FRAG_W    = 4;
  localparam int ERR_W     = 5;
  localparam int SBC_W     = 4;
  localparam int ID_W      = 16;

  typedef enum logic [1:0] {
    RSN_ERROR = 2'd0,
    RSN_ROUTE = 2'd1,
    RSN_FLUSH = 2'd2
  } push_rsn_e;

  typedef struct packed {
    logic [14:0]       rsvd;
    logic              eop;
    logic [SBC_W-1:0]  sbc;
    logic              fbar;
    logic [FRAG_W-1:0] frag;
    logic [ERR_W-1:0]  err;
    push_rsn_e         rsn;
  } ctl_word_t;
endpackage

// File: rtl/mdb_ppdu_ctx.sv
module mdb_ppdu_ctx
  import mdb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             stb_i,
  input  logic             clr_on_start_i,
  input  logic             mark_load_i,
  output logic [ID_W-1:0]  id_o,
  output logic [SBC_W-1:0] sbc_o
);
  localparam logic [SBC_W-1:0] SBC_MAX = {SBC_W{1'b1}};

  logic [ID_W-1:0]  id_q, id_n;
  logic [SBC_W-1:0] sbc_q, sbc_n;
  logic             id_en, sbc_en;

  always_comb begin
    id_en  = start_i;
    id_n   = id_i;
    sbc_en = 1'b0;
    sbc_n  = sbc_q;
    if (mark_load_i || (start_i && clr_on_start_i)) begin
      sbc_en = 1'b1;
      sbc_n  = '0;
    end else if (stb_i && (sbc_q != SBC_MAX)) begin
      sbc_en = 1'b1;
      sbc_n  = sbc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      sbc_q <= '0;
    end else begin
      if (id_en)  id_q  <= id_n;
      if (sbc_en) sbc_q <= sbc_n;
    end
  end

  assign id_o  = id_q;
  assign sbc_o = sbc_q;
endmodule

// File: rtl/mdb_mark_q.sv
module mdb_mark_q (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic end_i,
  input  logic flush_i,
  input  logic take_i,
  output logic pend_o,
  output logic flush_o
);
  logic pend_q, pend_n, fl_q, fl_n;

  always_comb begin
    pend_n = take_i ? 1'b0 : pend_q;
    fl_n   = take_i ? 1'b0 : fl_q;
    if (en_i && (end_i || flush_i)) begin
      pend_n = 1'b1;
      fl_n   = fl_n | flush_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      fl_q   <= 1'b0;
    end else begin
      pend_q <= pend_n;
      fl_q   <= fl_n;
    end
  end

  assign pend_o  = pend_q;
  assign flush_o = fl_q;
endmodule

// File: rtl/mdb_fmt.sv
module mdb_fmt
  import mdb_pkg::*;
(
  input  logic              mark_i,
  input  logic              mark_flush_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MSDU_W-1:0] msdu_i,
  input  logic              frag_flag_i,
  input  logic [FRAG_W-1:0] frag_i,
  input  logic [TID_W-1:0]  tid_i,
  input  logic              fbar_i,
  input  logic              err_i,
  input  logic [ERR_W-1:0]  code_i,
  input  logic [SBC_W-1:0]  sbc_i,
  input  logic [ID_W-1:0]   id_i,
  output logic [DESC_W-1:0] desc_o
);
  logic [WORD_W-1:0] words [NUM_WORDS];
  ctl_word_t         ctl;
  logic              frame;

  always_comb begin
    frame     = !mark_i;
    ctl       = '0;
    ctl.eop   = mark_i;
    ctl.sbc   = sbc_i;
    if (mark_i) ctl.rsn = mark_flush_i ? RSN_FLUSH : RSN_ROUTE;
    else        ctl.rsn = err_i ? RSN_ERROR : RSN_ROUTE;
    ctl.err   = (frame && err_i) ? code_i : '0;
    ctl.frag  = (frame && frag_flag_i) ? frag_i : '0;
    ctl.fbar  = frame && fbar_i;

    for (int w = 0; w < NUM_WORDS; w++) words[w] = '0;
    if (frame) begin
      words[0] = addr_i[ADDR_LO_W-1:0];
      words[1][ADDR_HI_W-1:0] = addr_i[ADDR_W-1:ADDR_LO_W];
      words[2][MSDU_W-1:0] = msdu_i;
      words[2][MSDU_W]     = frag_flag_i;
      words[2][WORD_W-1 -: TID_W] = tid_i;
    end
    words[6] = ctl;
    words[7][ID_W-1:0] = id_i;
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_pack
    assign desc_o[g*WORD_W +: WORD_W] = words[g];
  end
endmodule

// File: rtl/mdb_out_reg.sv
module mdb_out_reg
  import mdb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DESC_W-1:0] data_i,
  input  logic              rdy_i,
  output logic              vld_o,
  output logic [DESC_W-1:0] data_o,
  output logic              free_o
);
  logic              vld_q, vld_n;
  logic [DESC_W-1:0] data_q;

  always_comb begin
    free_o = !vld_q || rdy_i;
    if (load_i)     vld_n = 1'b1;
    else if (rdy_i) vld_n = 1'b0;
    else            vld_n = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (load_i) data_q <= data_i;
  end

  assign vld_o  = vld_q;
  assign data_o = data_q;
endmodule

// File: rtl/mon_desc_builder.sv
module mon_desc_builder
  import mdb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mark_en,
  input  logic              mpdu_vld,
  input  logic [ADDR_W-1:0] mpdu_link_addr,
  input  logic [MSDU_W-1:0] mpdu_msdu_cnt,
  input  logic              mpdu_frag_flag,
  input  logic [FRAG_W-1:0] mpdu_frag_num,
  input  logic [TID_W-1:0]  mpdu_tid,
  input  logic              mpdu_fbar,
  input  logic              mpdu_err,
  input  logic [ERR_W-1:0]  mpdu_err_code,
  input  logic              stat_buf_used,
  input  logic              ppdu_start,
  input  logic [ID_W-1:0]   ppdu_id_in,
  input  logic              ppdu_end,
  input  logic              ppdu_flush,
  output logic              desc_vld,
  input  logic              desc_rdy,
  output logic [DESC_W-1:0] desc_data,
  output logic              ovf_sticky
);
  logic              slot_free, mark_pend, mark_flush, mark_load, mpdu_acc, load;
  logic [ID_W-1:0]   cur_id;
  logic [SBC_W-1:0]  cur_sbc;
  logic [DESC_W-1:0] next_desc;
  logic              ovf_q, ovf_n;

  always_comb begin
    mark_load = mark_pend && slot_free;
    mpdu_acc  = mpdu_vld && slot_free && !mark_pend;
    load      = mark_load || mpdu_acc;
    ovf_n     = ovf_q || (mpdu_vld && !mpdu_acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_n;
  end

  mdb_ppdu_ctx u_ctx (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (ppdu_start),
    .id_i           (ppdu_id_in),
    .stb_i          (stat_buf_used),
    .clr_on_start_i (!cfg_mark_en),
    .mark_load_i    (mark_load),
    .id_o           (cur_id),
    .sbc_o          (cur_sbc)
  );

  mdb_mark_q u_markq (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (cfg_mark_en),
    .end_i   (ppdu_end),
    .flush_i (ppdu_flush),
    .take_i  (mark_load),
    .pend_o  (mark_pend),
    .flush_o (mark_flush)
  );

  mdb_fmt u_fmt (
    .mark_i       (mark_pend),
    .mark_flush_i (mark_flush),
    .addr_i       (mpdu_link_addr),
    .msdu_i       (mpdu_msdu_cnt),
    .frag_flag_i  (mpdu_frag_flag),
    .frag_i       (mpdu_frag_num),
    .tid_i        (mpdu_tid),
    .fbar_i       (mpdu_fbar),
    .err_i        (mpdu_err),
    .code_i       (mpdu_err_code),
    .sbc_i        (cur_sbc),
    .id_i         (cur_id),
    .desc_o       (next_desc)
  );

  mdb_out_reg u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .data_i (next_desc),
    .rdy_i  (desc_rdy),
    .vld_o  (desc_vld),
    .data_o (desc_data),
    .free_o (slot_free)
  );

  assign ovf_sticky = ovf_q;
endmodule

// File: rtl/mdb_checker.sv
module mdb_checker
  import mdb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              desc_vld,
  input logic              desc_rdy,
  input logic [DESC_W-1:0] desc_data,
  input logic              ovf_sticky
);
  logic [WORD_W-1:0] w2, w6, w7;
  logic              frame_zero;
  assign w2 = desc_data[2*WORD_W +: WORD_W];
  assign w6 = desc_data[6*WORD_W +: WORD_W];
  assign w7 = desc_data[7*WORD_W +: WORD_W];
  assign frame_zero = (desc_data[4*WORD_W-1:0] == '0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld && !desc_rdy |=> desc_vld && $stable(desc_data));

  assert_reason_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld |-> w6[1:0] != 2'd3);

  assert_code_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld && (w6[1:0] != 2'd0) |-> w6[6:2] == '0);

  assert_frag_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld && !w2[8] |-> w6[10:7] == '0);

  assert_marker_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld && w6[16] |-> frame_zero && (w6[11:7] == '0));

  assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld |-> (w7[31:16] == '0) && (w6[31:17] == '0));

  assert_no_overflow_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sticky |=> ovf_sticky);
endmodule

bind mon_desc_builder mdb_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .desc_vld   (desc_vld),
  .desc_rdy   (desc_rdy),
  .desc_data  (desc_data),
  .ovf_sticky (ovf_sticky)
);

// File: tb/mon_desc_builder_bench.sv
module mon_desc_builder_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_mark_en, mpdu_vld, mpdu_frag_flag, mpdu_fbar, mpdu_err;
  logic [39:0]  mpdu_link_addr;
  logic [7:0]   mpdu_msdu_cnt;
  logic [3:0]   mpdu_frag_num, mpdu_tid;
  logic [4:0]   mpdu_err_code;
  logic         stat_buf_used, ppdu_start, ppdu_end, ppdu_flush, desc_rdy;
  logic [15:0]  ppdu_id_in;
  logic         desc_vld, ovf_sticky;
  logic [255:0] desc_data;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mon_desc_builder u_mon_desc_builder (.*);

  function automatic logic [31:0] wd(input int n);
    return desc_data[n*32 +: 32];
  endfunction

  function automatic logic [31:0] ctl(input logic eop, input logic [3:0] sbc,
      input logic fb, input logic [3:0] fr, input logic [4:0] ec, input logic [1:0] rs);
    return {15'd0, eop, sbc, fb, fr, ec, rs};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step; @(negedge clk); endtask

  task automatic clear_in;
    mpdu_vld = 0; stat_buf_used = 0; ppdu_start = 0; ppdu_end = 0; ppdu_flush = 0;
  endtask

  task automatic begin_ppdu(input logic [15:0] id);
    logic en;
    en = cfg_mark_en;
    cfg_mark_en = 0; ppdu_start = 1; ppdu_id_in = id;
    step; clear_in; cfg_mark_en = en;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin stat_buf_used = 1; step; end
    clear_in;
  endtask

  task automatic set_mpdu(input logic [39:0] a, input logic [7:0] m, input logic ff,
      input logic [3:0] fn, input logic [3:0] t, input logic fb, input logic e, input logic [4:0] c);
    mpdu_vld = 1; mpdu_link_addr = a; mpdu_msdu_cnt = m; mpdu_frag_flag = ff;
    mpdu_frag_num = fn; mpdu_tid = t; mpdu_fbar = fb; mpdu_err = e; mpdu_err_code = c;
  endtask

  task automatic t_reset;
    chk("R12 valid", {31'd0, desc_vld}, 32'd0);
    chk("R12 ovf", {31'd0, ovf_sticky}, 32'd0);
  endtask

  task automatic t_normal;
    begin_ppdu(16'h1234);
    strobes(3);
    set_mpdu(40'hA5_DEAD_BEEF, 8'd7, 0, 4'd5, 4'd6, 0, 0, 5'd9);
    step; clear_in;
    chk("R1 valid", {31'd0, desc_vld}, 32'd1);
    chk("R1 w0", wd(0), 32'hDEAD_BEEF);
    chk("R1 w1", wd(1), 32'h0000_00A5);
    chk("R1 w2", wd(2), 32'h6000_0007);
    chk("R1 w3", wd(3) | wd(4) | wd(5), 32'd0);
    chk("R2 R3 R4 R7 w6", wd(6), ctl(0, 4'd3, 0, 4'd0, 5'd0, 2'd1));
    chk("R8 w7", wd(7), 32'h0000_1234);
    step;
    chk("R1 drained", {31'd0, desc_vld}, 32'd0);
  endtask

  task automatic t_error;
    begin_ppdu(16'h0042);
    set_mpdu(40'h01_0000_0010, 8'd1, 1, 4'd9, 4'd2, 1, 1, 5'd13);
    step; clear_in;
    chk("R2 R3 R4 R5 err w6", wd(6), ctl(0, 4'd0, 1, 4'd9, 5'd13, 2'd0));
    chk("R1 frag flag w2", wd(2), 32'h2000_0101);
    step;
  endtask

  task automatic t_marker(input logic fl);
    cfg_mark_en = 1;
    begin_ppdu(16'hBEEF);
    strobes(2);
    if (fl) ppdu_flush = 1; else ppdu_end = 1;
    step; clear_in;
    chk("R6 no early marker", {31'd0, desc_vld}, 32'd0);
    step;
    chk("R6 marker valid", {31'd0, desc_vld}, 32'd1);
    chk("R6 frame zero", wd(0) | wd(1) | wd(2) | wd(3), 32'd0);
    chk(fl ? "R2 R6 flush w6" : "R2 R6 end w6", wd(6),
        ctl(1, 4'd2, 0, 4'd0, 5'd0, fl ? 2'd2 : 2'd1));
    chk("R8 marker id", wd(7), 32'h0000_BEEF);
    set_mpdu(40'd5, 8'd2, 0, 4'd0, 4'd0, 0, 0, 5'd0);
    step; clear_in;
    chk("R7 cleared after marker", wd(6), ctl(0, 4'd0, 0, 4'd0, 5'd0, 2'd1));
    step;
  endtask

  task automatic t_disabled;
    cfg_mark_en = 0;
    begin_ppdu(16'h0007);
    strobes(4);
    ppdu_end = 1; step; clear_in;
    ppdu_flush = 1; step; clear_in;
    step; step;
    chk("R6 disabled no marker", {31'd0, desc_vld}, 32'd0);
    begin_ppdu(16'h0008);
    set_mpdu(40'd1, 8'd1, 0, 4'd0, 4'd0, 0, 0, 5'd0);
    step; clear_in;
    chk("R7 start clears count", wd(6), ctl(0, 4'd0, 0, 4'd0, 5'd0, 2'd1));
    chk("R8 new id", wd(7), 32'h0000_0008);
    step;
  endtask

  task automatic t_saturate;
    begin_ppdu(16'h0009);
    strobes(20);
    set_mpdu(40'd1, 8'd1, 0, 4'd0, 4'd0, 0, 0, 5'd0);
    step; clear_in;
    chk("R7 saturate", {28'd0, wd(6)[15:12]}, 32'd15);
    step;
  endtask

  task automatic t_stall;
    logic [255:0] snap;
    cfg_mark_en = 1;
    begin_ppdu(16'h0A0A);
    desc_rdy = 0;
    set_mpdu(40'h11_2222_3333, 8'd3, 0, 4'd0, 4'd1, 0, 0, 5'd0);
    step; clear_in;
    snap = desc_data;
    step; step;
    chk("R9 hold valid", {31'd0, desc_vld}, 32'd1);
    chk("R9 hold data", {31'd0, desc_data === snap}, 32'd1);
    chk("R10 no ovf yet", {31'd0, ovf_sticky}, 32'd0);
    set_mpdu(40'h99_9999_9999, 8'd9, 0, 4'd0, 4'd0, 0, 0, 5'd0);
    step; clear_in;
    chk("R10 ovf set", {31'd0, ovf_sticky}, 32'd1);
    chk("R10 data kept", wd(0), 32'h2222_3333);
    ppdu_end = 1; step; clear_in;
    chk("R11 MPDU still first", {31'd0, wd(6)[16]}, 32'd0);
    desc_rdy = 1; step;
    chk("R11 marker after MPDU", {31'd0, desc_vld & wd(6)[16]}, 32'd1);
    step;
    chk("R11 single marker", {31'd0, desc_vld}, 32'd0);
    chk("R10 ovf sticky", {31'd0, ovf_sticky}, 32'd1);
  endtask

  task automatic t_same_cycle;
    cfg_mark_en = 1;
    begin_ppdu(16'h0B0B);
    set_mpdu(40'h00_0000_0ABC, 8'd4, 0, 4'd0, 4'd0, 0, 0, 5'd0);
    ppdu_end = 1;
    step; clear_in;
    chk("R11 same-cycle MPDU first", {wd(6)[16], wd(0)[30:0]}, 32'h0000_0ABC);
    step;
    chk("R11 same-cycle marker next", {31'd0, desc_vld & wd(6)[16]}, 32'd1);
    step;
  endtask

  initial begin
    rst_n = 0; cfg_mark_en = 0; desc_rdy = 1; ppdu_id_in = '0;
    mpdu_link_addr = '0; mpdu_msdu_cnt = '0; mpdu_frag_flag = 0; mpdu_frag_num = '0;
    mpdu_tid = '0; mpdu_fbar = 0; mpdu_err = 0; mpdu_err_code = '0;
    clear_in;
    step; step;
    rst_n = 1;
    step;
    t_reset;
    t_normal;
    t_error;
    t_marker(0);
    t_marker(1);
    t_disabled;
    t_saturate;
    t_same_cycle;
    t_stall;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule